// File: doc/BRIEF.md
# TDM Clock and Frame Pulse Generator

This block produces a set of programmable TDM bit clocks, each with a matching frame pulse, from a single fast reference clock. Every output channel has its own configuration register. The register selects one of four bit rates, which edge of the clock is the active one, whether the frame pulse is active high or active low, whether the channel is enabled, and which of two timing bases it follows. One timing base runs freely from reset. The other tracks the frame alignment of an incoming frame pulse.

Inside the block, a frame is 2^FRAME_LOG2 reference cycles long. With the default value of 14 and a 131.072 MHz reference, that is 125 µs, so frame pulses repeat at 8 kHz. Each output clock is a tap of a frame-phase counter. The frame pulse covers the first output-clock period of every frame. A new rate is held pending and takes effect at the next frame boundary of the channel, so no clock or pulse period is cut short.

The incoming frame pulse is synchronised, filtered by a minimum width that depends on the input rate, and then used to realign the tracking base. A loss-of-frame flag is raised when no valid pulse arrives for two frames. A global output-enable input is combined with the enable bit of each channel to produce a drive enable for the pads of that channel.

Top module: `tdm_clkgen`

## Requirements
- R1: Bits [1:0] of a channel's configuration set its rate. The codes 00, 01, 10 and 11 give output clock half-periods of 8, 4, 2 and 1 reference cycles, which is 8.192, 16.384, 32.768 and 65.536 MHz from a 131.072 MHz reference.
- R2: A frame lasts 2^FRAME_LOG2 reference cycles at every rate. The frame pulse is active for exactly the first output-clock period of each frame (2^(4-rate) reference cycles) and is inactive for the rest of the frame.
- R3: Bit 3 of the configuration sets frame pulse polarity: 0 makes the pulse active low and 1 makes it active high.
- R4: Bit 2 of the configuration sets the active edge. With 0 (rising), the clock is low in the first half of each period and rises at its midpoint. With 1 (falling), the clock is inverted.
- R5: Bit 4 of the configuration selects the timing base. With 0, the channel follows the internal base, which starts a frame in the first cycle after reset. With 1, it follows the tracking base, which is realigned by the incoming frame pulse.
- R6: The frame pulse input `fp_in` is active low and passes through two synchroniser stages. Once it has been sampled low for 2^(4-in_rate) consecutive reference edges, the tracking base is realigned. After realignment, the tracking-base frame starts in the cycle that follows the first edge at which the pin was sampled low.
- R7: An input pulse that stays active for fewer than 2^(4-in_rate) consecutive edges does not change the tracking base.
- R8: `lof` rises after 2^(FRAME_LOG2+1) reference edges with no qualified input pulse, counted from reset or from the last qualified pulse. A qualified pulse clears `lof`.
- R9: A rate written to a channel takes effect only at the next frame boundary of that channel's base. The rest of the current frame keeps the old rate.
- R10: `out_en[i]` is high exactly when `oe` is high and bit 5 (enable) of channel i's configuration is set.
- R11: After reset, every channel has rate 00, rising edge, an active-low pulse, the internal source and enable cleared, and `lof` is low.
- R12: A write with `cfg_we` high loads `cfg_wdata` into channel `cfg_idx` at the clock edge. All other channels are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDXW | Channel selected by the write |
| cfg_wdata | input | 6 | Configuration: [1:0] rate, [2] falling edge, [3] active-high pulse, [4] tracking source, [5] enable |
| fp_in | input | 1 | Incoming frame pulse, active low |
| in_rate | input | 2 | Rate code of the incoming frame pulse (sets the qualification width) |
| oe | input | 1 | Global output enable |
| ck_out | output | N_OUT | Output bit clocks |
| fp_out | output | N_OUT | Output frame pulses |
| out_en | output | N_OUT | Drive enable for each channel's outputs |
| lof | output | 1 | Loss-of-frame flag |

## Verification
The bench writes a new rate in the middle of a frame. A design that applies the rate at once produces a short clock period and a clipped frame pulse before the boundary. It realigns the tracking base with an input pulse whose phase is well away from the current frame start. A wrong synchroniser latency shifts the tracking-sourced frame pulse by some cycles, and a missing realignment leaves it at the internal phase. A pulse one cycle shorter than the qualification width must leave alignment untouched, which exposes an off-by-one width filter. `lof` is sampled on the edge just before its two-frame limit and on the edge at the limit, which catches a count that is off by one.

// File: rtl/tdm_clkgen_pkg.sv
// Package: shared configuration type and reset value for the TDM clock generator.
// Assumes a 6-bit channel configuration word, laid out as the packed struct below.
package tdm_clkgen_pkg;

    // Channel configuration; the bit positions are visible through cfg_wdata.
    typedef struct packed {
        logic       en;       // [5] drive enable
        logic       ext;      // [4] follow tracking base
        logic       fp_high;  // [3] active-high frame pulse
        logic       fall;     // [2] falling active edge
        logic [1:0] rate;     // [1:0] rate code
    } ocfg_t;

    localparam int OCFG_W = 6;

    localparam ocfg_t OCFG_RST = '{en: 1'b0, ext: 1'b0, fp_high: 1'b0,
                                   fall: 1'b0, rate: 2'b00};

endpackage

// File: rtl/tdm_frame_base.sv
// Module: frame-phase counter, FL bits wide, counting reference cycles.
// It wraps once per frame and can be loaded with a new phase for realignment.
// Assumes that load is asserted for one cycle at a time.
module tdm_frame_base #(
    parameter int FL = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [FL-1:0] load_val,
    output logic [FL-1:0] cnt,
    output logic          wrap
);

    // Advance the phase, or take the realignment value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else begin
            cnt <= cnt + {{(FL-1){1'b0}}, 1'b1};
        end
    end

    // Last cycle of the frame.
    always_comb wrap = (cnt == {FL{1'b1}});

endmodule

// File: rtl/tdm_in_align.sv
// Module: incoming frame pulse handling.
// It synchronises fp_in (active low) through two stages, qualifies a pulse once
// it has been active for one input-clock period (2^(4-in_rate) reference
// cycles), returns the phase to load into the tracking base, and keeps the
// loss-of-frame flag. Assumes FL >= 6.
module tdm_in_align #(
    parameter int FL = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fp_in,
    input  logic [1:0]    in_rate,
    output logic          qual,
    output logic [FL-1:0] load_val,
    output logic          lof
);

    localparam int MW = FL + 1;

    logic          s1, s2;
    logic          act;
    logic [4:0]    wcnt;
    logic [4:0]    per;
    logic [MW-1:0] mc;

    // Two-stage synchroniser; resets to the inactive (high) level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= fp_in;
            s2 <= s1;
        end
    end

    // Width of one input-clock period in reference cycles, and the qualify point.
    always_comb begin
        act      = ~s2;
        per      = 5'd1 << (3'd4 - {1'b0, in_rate});
        qual     = act && (wcnt == per - 5'd1);
        // The qualifying cycle is the per-th after the pin's first low sample,
        // so the next cycle of the frame has phase per + 1.
        load_val = {{(FL-5){1'b0}}, per} + {{(FL-1){1'b0}}, 1'b1};
    end

    // Count consecutive active cycles, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !act) begin
            wcnt <= '0;
        end else if (wcnt != 5'd31) begin
            wcnt <= wcnt + 5'd1;
        end
    end

    // Count cycles without a qualified pulse; flag loss after two frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc  <= '0;
            lof <= 1'b0;
        end else if (qual) begin
            mc  <= '0;
            lof <= 1'b0;
        end else begin
            if (mc != {MW{1'b1}}) mc <= mc + {{(MW-1){1'b0}}, 1'b1};
            if (mc == {MW{1'b1}}) lof <= 1'b1;
        end
    end

    // R6: a held pulse qualifies once, not on every cycle it stays active.
    p_qual_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        qual |=> !qual);

    // R8: a qualified pulse clears the flag.
    p_lof_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        qual |=> !lof);

    // R8: the flag never rises in the cycle after a qualified pulse.
    p_lof_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lof) |-> $past(!qual));

endmodule

// File: rtl/tdm_out_chan.sv
// Module: one output channel.
// It holds the channel's configuration and derives its clock and frame pulse
// from taps of the selected frame-phase counter. The rate is applied only at
// the selected base's frame wrap. Assumes FL >= 6.
module tdm_out_chan
    import tdm_clkgen_pkg::*;
#(
    parameter int FL = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  ocfg_t         wdata,
    input  logic [FL-1:0] int_cnt,
    input  logic          int_wrap,
    input  logic [FL-1:0] trk_cnt,
    input  logic          trk_wrap,
    input  logic          oe,
    output logic          ck_o,
    output logic          fp_o,
    output logic          en_o
);

    ocfg_t         cfg;
    logic [1:0]    rate_act;
    logic [FL-1:0] base;
    logic          base_wrap;
    logic [1:0]    k;
    logic [2:0]    k1;
    logic          pulse;

    // Configuration register, loaded by a write to this channel.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg <= OCFG_RST;
        else if (wr) cfg <= wdata;
    end

    // Apply the pending rate only at the end of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) rate_act <= 2'b00;
        else if (base_wrap) rate_act <= cfg.rate;
    end

    // Pick the base and form the clock, pulse and drive enable from its taps.
    always_comb begin
        base      = cfg.ext ? trk_cnt : int_cnt;
        base_wrap = cfg.ext ? trk_wrap : int_wrap;
        k         = 2'd3 - rate_act;
        k1        = {1'b0, k} + 3'd1;
        pulse     = ((base >> k1) == '0);
        ck_o      = base[k] ^ cfg.fall;
        fp_o      = cfg.fp_high ? pulse : ~pulse;
        en_o      = oe & cfg.en;
    end

    // R9: the active rate changes only after a frame wrap.
    p_rate_at_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_act != $past(rate_act)) |-> $past(base_wrap));

    // R2: on the internal base, a frame pulse starts only after a frame wrap.
    p_fp_start_at_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.ext && $past(!cfg.ext) && $rose(pulse)) |-> $past(int_wrap));

endmodule

// File: rtl/tdm_clkgen.sv
// Module: top of the TDM clock and frame pulse generator.
// It contains a free-running internal frame base, a tracking frame base that
// realigns to qualified input pulses, and N_OUT configurable output channels.
// Assumes N_OUT >= 2 and FRAME_LOG2 >= 6.
module tdm_clkgen
    import tdm_clkgen_pkg::*;
#(
    parameter int N_OUT      = 2,
    parameter int FRAME_LOG2 = 14,
    localparam int IDXW      = $clog2(N_OUT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDXW-1:0]  cfg_idx,
    input  logic [OCFG_W-1:0] cfg_wdata,
    input  logic             fp_in,
    input  logic [1:0]       in_rate,
    input  logic             oe,
    output logic [N_OUT-1:0] ck_out,
    output logic [N_OUT-1:0] fp_out,
    output logic [N_OUT-1:0] out_en,
    output logic             lof
);

    logic [FRAME_LOG2-1:0] int_cnt, trk_cnt, trk_load_val;
    logic                  int_wrap, trk_wrap, trk_load;

    tdm_frame_base #(.FL(FRAME_LOG2)) u_int_base (
        .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val('0),
        .cnt(int_cnt), .wrap(int_wrap)
    );

    tdm_in_align #(.FL(FRAME_LOG2)) u_align (
        .clk(clk), .rst_n(rst_n), .fp_in(fp_in), .in_rate(in_rate),
        .qual(trk_load), .load_val(trk_load_val), .lof(lof)
    );

    tdm_frame_base #(.FL(FRAME_LOG2)) u_trk_base (
        .clk(clk), .rst_n(rst_n), .load(trk_load), .load_val(trk_load_val),
        .cnt(trk_cnt), .wrap(trk_wrap)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_chan
        logic wr_i;
        always_comb wr_i = cfg_we && (cfg_idx == IDXW'(i));
        tdm_out_chan #(.FL(FRAME_LOG2)) u_chan (
            .clk(clk), .rst_n(rst_n), .wr(wr_i), .wdata(ocfg_t'(cfg_wdata)),
            .int_cnt(int_cnt), .int_wrap(int_wrap),
            .trk_cnt(trk_cnt), .trk_wrap(trk_wrap), .oe(oe),
            .ck_o(ck_out[i]), .fp_o(fp_out[i]), .en_o(out_en[i])
        );
    end

endmodule

// File: tb/tdm_clkgen_test.sv
// Directed bench for tdm_clkgen. A small frame (FRAME_LOG2 = 8) keeps runs
// short. A reference model of the two frame phases, built from the
// requirements, is checked against every output on each falling edge.
module tdm_clkgen_test;

    localparam int FL  = 8;
    localparam int N   = 2;
    localparam int FRM = 1 << FL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [0:0]    cfg_idx = '0;
    logic [5:0]    cfg_wdata = '0;
    logic          fp_in = 1'b1;
    logic [1:0]    in_rate = 2'b00;
    logic          oe = 1'b0;
    logic [N-1:0]  ck_out, fp_out, out_en;
    logic          lof;

    always #5 clk = ~clk;

    tdm_clkgen #(.N_OUT(N), .FRAME_LOG2(FL)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .fp_in(fp_in), .in_rate(in_rate), .oe(oe),
        .ck_out(ck_out), .fp_out(fp_out), .out_en(out_en), .lof(lof)
    );

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    bit    mon = 0;
    string cur_req = "R11";

    // Reference model: frame phases and channel configuration.
    int ph = 0, tph = 0, nact = 0;
    bit align_next = 0;
    int act_r[N], pend_r[N];
    bit fall_r[N], fph_r[N], ext_r[N], en_r[N];

    task automatic chk(input bit ok, input string req, input string what,
                       input int a, input int e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (ph=%0d)", req, what, a, e, ph);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; tph = 0; nact = 0;
            for (int i = 0; i < N; i++) begin
                act_r[i] = 0; pend_r[i] = 0; fall_r[i] = 0;
                fph_r[i] = 0; ext_r[i] = 0; en_r[i] = 0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                int b;
                b = ext_r[i] ? tph : ph;
                if (b == FRM - 1) act_r[i] = pend_r[i];
            end
            ph   = (ph + 1) % FRM;
            tph  = align_next ? 0 : (tph + 1) % FRM;
            align_next = 0;
            nact++;
            if (cfg_we) begin
                pend_r[cfg_idx] = cfg_wdata[1:0];
                fall_r[cfg_idx] = cfg_wdata[2];
                fph_r[cfg_idx]  = cfg_wdata[3];
                ext_r[cfg_idx]  = cfg_wdata[4];
                en_r[cfg_idx]   = cfg_wdata[5];
            end
        end
    end

    // Continuous comparison of clocks and frame pulses with the model.
    always @(negedge clk) begin
        if (mon && rst_n) begin
            for (int i = 0; i < N; i++) begin
                int b, k, eck, efp;
                b   = ext_r[i] ? tph : ph;
                k   = 3 - act_r[i];
                eck = ((b >> k) & 1) ^ int'(fall_r[i]);
                efp = (b < (1 << (k + 1))) ? 1 : 0;
                if (!fph_r[i]) efp = 1 - efp;
                chk(ck_out[i] == eck[0], cur_req, $sformatf("ck_out[%0d]", i), ck_out[i], eck);
                chk(fp_out[i] == efp[0], cur_req, $sformatf("fp_out[%0d]", i), fp_out[i], efp);
            end
        end
    end

    task automatic wcfg(input int idx, input logic [5:0] d);
        cfg_idx   = idx[0:0];
        cfg_wdata = d;
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic wait_ph(input int p);
        do @(negedge clk); while (ph != p);
    endtask

    // R11: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk(out_en == 2'b00, "R11", "out_en after reset", out_en, 0);
        chk(lof == 1'b0, "R11", "lof after reset", lof, 0);
        chk(fp_out[0] == 1'b0, "R11", "fp_out[0] active low at frame start", fp_out[0], 0);
        chk(ck_out[0] == 1'b0, "R11", "ck_out[0] low at frame start", ck_out[0], 0);
        mon = 1;
    endtask

    // R8: loss of frame after two frames with no pulse.
    task automatic t_lof();
        cur_req = "R2";
        do @(negedge clk); while (nact != 2 * FRM - 1);
        chk(lof == 1'b0, "R8", "lof one edge before limit", lof, 0);
        @(negedge clk);
        chk(lof == 1'b1, "R8", "lof at limit", lof, 1);
    endtask

    // R1, R9: every rate, each written mid-frame.
    task automatic t_rates();
        for (int r = 3; r >= 0; r--) begin
            wait_ph(100);
            cur_req = "R9";
            wcfg(0, {4'b0000, 2'(r)});
            wait_ph(0);
            cur_req = "R1";
            repeat (FRM) @(negedge clk);
        end
    endtask

    // R4, R3, R12: edge and polarity on channel 1; channel 0 must not move.
    task automatic t_edge_pol();
        wait_ph(30);
        cur_req = "R12";
        wcfg(1, 6'b000110);
        repeat (FRM) @(negedge clk);
        cur_req = "R4";
        repeat (FRM) @(negedge clk);
        wait_ph(60);
        cur_req = "R3";
        wcfg(1, 6'b001010);
        repeat (2 * FRM) @(negedge clk);
        wcfg(1, 6'b000000);
        wait_ph(0);
    endtask

    // R10: drive enables.
    task automatic t_enable();
        oe = 1'b0;
        wcfg(0, 6'b100000);
        chk(out_en == 2'b00, "R10", "oe low", out_en, 0);
        oe = 1'b1;
        @(negedge clk);
        chk(out_en == 2'b01, "R10", "oe high ch0 only", out_en, 1);
        wcfg(1, 6'b100000);
        chk(out_en == 2'b11, "R10", "both enabled", out_en, 3);
        oe = 1'b0;
        @(negedge clk);
        chk(out_en == 2'b00, "R10", "oe low again", out_en, 0);
    endtask

    // R5, R6: realign the tracking base to a pulse at an offset phase.
    task automatic t_align();
        in_rate = 2'b00;
        wcfg(1, 6'b110000);
        wait_ph(100);
        mon = 0;
        fp_in = 1'b0;
        align_next = 1;
        repeat (16) @(negedge clk);
        fp_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(lof == 1'b0, "R8", "lof cleared by qualified pulse", lof, 0);
        cur_req = "R6";
        mon = 1;
        repeat (2 * FRM) @(negedge clk);
        do @(negedge clk); while (tph != 0);
        chk(fp_out[1] == 1'b0, "R5", "tracking pulse at tracking frame start", fp_out[1], 0);
        chk(fp_out[0] == 1'b1, "R5", "internal pulse idle there", fp_out[0], 1);
    endtask

    // R7: a pulse one cycle short leaves alignment alone.
    task automatic t_short();
        wait_ph(50);
        cur_req = "R7";
        fp_in = 1'b0;
        repeat (15) @(negedge clk);
        fp_in = 1'b1;
        repeat (2 * FRM) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_lof();
        t_rates();
        t_edge_pol();
        t_enable();
        t_align();
        t_short();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule